// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock plus bidirectional data, open-drain). It holds three byte-wide configuration registers: two output-enable registers and one test register. Their current values are presented in parallel on `cfg_q` to the logic they control. A host controller reaches them through a fixed 7-bit bus address.

Both bus lines are sampled by the system clock through two-flop synchronisers. START, repeated START and STOP are recognised from data-line transitions while the bus clock is high. After the address byte, a command byte chooses between two kinds of access. One is a single-byte access to an indexed register. The other is a block access that always starts at register 0. For a block write, the host sends a byte count before the data. For a block read, the slave sends a byte count before the data.

The slave acknowledges by pulling the data line low and sends read data MSB first. It never holds the bus clock.

Top module: `cfg_twowire_slave`

## Requirements
- R1: After reset, `cfg_q` is 24'hFFC0FF and `sda_oe` is 0. In `cfg_q`, register 0 is bits 7:0, register 1 is bits 15:8 and register 2 is bits 23:16.
- R2: The slave acknowledges only the address 7'b1101001: 0xD2 with the write bit and 0xD3 with the read bit. For any other address it leaves the data line released for that byte's acknowledge slot and for every byte until the next START. Those bytes change no register.
- R3: A command byte with bit 7 = 1 selects single-byte access, and bits 6:0 give the register index. In a write transfer, the data byte that follows is stored at that index. Address, command and data bytes are each acknowledged.
- R4: A single-byte read is: a write-addressed command, then a repeated START, then 0xD3. The slave then sends the indexed register's value MSB first.
- R5: A command byte with bit 7 = 0 selects block access. In a block write, the first byte after the command is a count and is stored nowhere. The data bytes that follow go into registers 0, 1, 2 in that order.
- R6: A block read is a block command, then a repeated START, then 0xD3. The slave first sends the count 0x03, then registers 0, 1, 2 in ascending order.
- R7: The host may end a block write with STOP after any complete byte. Only the registers whose data bytes were delivered change.
- R8: A write to a register index of 3 or above is acknowledged and discarded. A read of such an index returns 0x00.
- R9: The slave pulls the data line low only during an acknowledge slot or for a 0 bit of read data. After the host answers a read byte with NACK, the slave leaves the line released until the next START. A STOP returns the slave to idle with the line released.
- R10: `sda_oe` changes only while the synchronised bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_q | output | 24 | Register contents: reg 2, reg 1, reg 0 from MSB to LSB |

## Verification
The bench targets the points where a slave most often loses its place in the byte stream.

- Partial block write: a block write ended after two data bytes. A design that counted the count byte as data would write it into register 0.
- Leading count on block read: a block read must begin with the count. A design without the count would start with register 0, and all later bytes would shift by one position.
- Clocking after NACK: the host keeps clocking after it sends NACK. A slave that missed the NACK would go on driving the next register and corrupt the line.
- Wrong address: traffic to a wrong address must produce neither an acknowledge nor a register write.
- Unimplemented index: a write to an index beyond the bank must alias onto no real register.

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave #(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int NUM_REGS = 3,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = 24'hFFC0FF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_q
);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_WCNT, ST_WDATA, ST_TX} st_t;

  st_t        state;
  logic [1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg, rd_byte, next_tx;
  logic [6:0] ptr;
  logic       cnt_pending, host_nack;

  wire scl_s     = scl_sync[1];
  wire sda_s     = sda_sync[1];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(ptr) == i) rd_byte = cfg_q[i*8 +: 8];
  end

  assign next_tx = cnt_pending ? COUNT_BYTE : rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      txreg       <= '0;
      ptr         <= '0;
      cnt_pending <= 1'b0;
      host_nack   <= 1'b0;
      sda_oe      <= 1'b0;
      cfg_q       <= RESET_VAL;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          if (state != ST_TX) shreg <= {shreg[6:0], sda_s};
        end else if (bitcnt == 4'd8 && state == ST_TX) begin
          host_nack <= sda_s;
        end
        if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (state == ST_TX) begin
            if (host_nack) begin
              state  <= ST_IDLE;
              sda_oe <= 1'b0;
            end else begin
              txreg  <= next_tx;
              sda_oe <= ~next_tx[7];
              if (cnt_pending) cnt_pending <= 1'b0;
              else if (ptr != 7'h7F) ptr <= ptr + 7'd1;
            end
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          case (state)
            ST_ADDR:
              if (shreg[7:1] == SLAVE_ADDR) begin
                sda_oe    <= 1'b1;
                host_nack <= 1'b0;
                state     <= shreg[0] ? ST_TX : ST_CMD;
              end else begin
                state <= ST_IDLE;
              end
            ST_CMD: begin
              sda_oe      <= 1'b1;
              cnt_pending <= ~shreg[7];
              ptr         <= shreg[7] ? shreg[6:0] : 7'd0;
              state       <= shreg[7] ? ST_WDATA : ST_WCNT;
            end
            ST_WCNT: begin
              sda_oe <= 1'b1;
              state  <= ST_WDATA;
            end
            ST_WDATA: begin
              sda_oe <= 1'b1;
              for (int i = 0; i < NUM_REGS; i++)
                if (int'(ptr) == i) cfg_q[i*8 +: 8] <= shreg;
              if (ptr != 7'h7F) ptr <= ptr + 7'd1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (state == ST_TX && bitcnt != 4'd0) begin
          txreg  <= {txreg[6:0], 1'b0};
          sda_oe <= ~txreg[6];
        end
      end
    end

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3
  reg_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> ($past(state) == ST_WDATA && $past(scl_fall)));

  // R9
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
endmodule

// File: tb/cfg_twowire_slave_tb.sv
module cfg_twowire_slave_tb;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_scl = 1'b1;
  logic        host_sda = 1'b1;
  logic        sda_oe;
  logic [23:0] cfg_q;
  wire         sda_line = host_sda & ~sda_oe;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cfg_twowire_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  // byte-write index, data written, expected read-back
  localparam logic [22:0] VEC [6] = '{
    {7'd0,  8'h3C, 8'h3C},
    {7'd1,  8'h80, 8'h80},
    {7'd2,  8'h7E, 8'h7E},
    {7'd5,  8'h5A, 8'h00},
    {7'h7F, 8'h11, 8'h00},
    {7'd0,  8'hA5, 8'hA5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    host_sda = b; qwait();
    host_scl = 1'b1; qwait(); qwait();
    host_scl = 1'b0; qwait();
  endtask

  task automatic bit_in(output logic b);
    host_sda = 1'b1; qwait();
    host_scl = 1'b1; qwait();
    b = sda_line; qwait();
    host_scl = 1'b0; qwait();
  endtask

  task automatic bus_start();
    host_sda = 1'b1; qwait();
    host_scl = 1'b1; qwait();
    host_sda = 1'b0; qwait();
    host_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; qwait();
    host_scl = 1'b1; qwait();
    host_sda = 1'b1; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_in(s); b[i] = s; end
    bit_out(nack);
  endtask

  task automatic byte_write(input logic [6:0] idx, input logic [7:0] d, input string req);
    logic a;
    bus_start();
    send_byte(8'hD2, a); check({req, " addr ack"}, a, 1);
    send_byte({1'b1, idx}, a); check({req, " cmd ack"}, a, 1);
    send_byte(d, a); check({req, " data ack"}, a, 1);
    bus_stop();
  endtask

  task automatic byte_read(input logic [6:0] idx, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte({1'b1, idx}, a);
    bus_start();
    send_byte(8'hD3, a); check("R4 read addr ack", a, 1);
    recv_byte(d, 1'b1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 cfg reset", cfg_q, 24'hFFC0FF);
    check("R1 sda released", sda_oe, 0);

    // R2 foreign address
    bus_start();
    send_byte(8'hA4, a); check("R2 no ack foreign addr", a, 0);
    send_byte(8'h80, a); check("R2 no ack later byte", a, 0);
    send_byte(8'h00, a); check("R2 no ack data", a, 0);
    bus_stop();
    check("R2 regs untouched", cfg_q, 24'hFFC0FF);

    // R3 R4 R8 table of byte writes and reads
    for (int i = 0; i < 6; i++) begin
      byte_write(VEC[i][22:16], VEC[i][15:8], "R3");
      byte_read(VEC[i][22:16], d);
      check("R4/R8 byte readback", d, VEC[i][7:0]);
    end
    check("R3/R8 cfg after table", cfg_q, 24'h7E80A5);

    // R5 block write
    bus_start();
    send_byte(8'hD2, a); check("R5 addr ack", a, 1);
    send_byte(8'h00, a); check("R5 cmd ack", a, 1);
    send_byte(8'h03, a); check("R5 count ack", a, 1);
    send_byte(8'h11, a); check("R5 data0 ack", a, 1);
    send_byte(8'h22, a); check("R5 data1 ack", a, 1);
    send_byte(8'h33, a); check("R5 data2 ack", a, 1);
    bus_stop();
    check("R5 block write result", cfg_q, 24'h332211);

    // R6 block read
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte(8'hD3, a); check("R6 read addr ack", a, 1);
    recv_byte(d, 1'b0); check("R6 count byte", d, 8'h03);
    recv_byte(d, 1'b0); check("R6 reg0", d, 8'h11);
    recv_byte(d, 1'b0); check("R6 reg1", d, 8'h22);
    recv_byte(d, 1'b1); check("R6 reg2", d, 8'h33);
    bus_stop();
    check("R9 released after stop", sda_oe, 0);

    // R7 partial block write
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h03, a);
    send_byte(8'h44, a);
    send_byte(8'h55, a);
    bus_stop();
    check("R7 partial block write", cfg_q, 24'h335544);

    // R9 host NACK then further clocking
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h81, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(d, 1'b1); check("R4 byte read reg1", d, 8'h55);
    recv_byte(d, 1'b1); check("R9 silent after nack", d, 8'hFF);
    bus_stop();
    check("R9 line idle", sda_oe, 0);

    // R1 reset again restores defaults
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cfg after second reset", cfg_q, 24'hFFC0FF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule